// File: doc/BRIEF.md
# DMA Channel Load Instruction Executor

This block runs the memory-read instruction of one DMA channel thread. When an instruction byte is offered, the block first checks whether the byte belongs to the load family. It then checks whether the channel is allowed to run it. Last, it checks whether the byte's conditional bit ties the load to the peripheral request type that the channel has latched. From these checks the block does one of three things: it retires the instruction as a no-operation, it raises a fault, or it starts a read burst on an AXI-style read address and read data channel.

During a load, the address comes from the channel's source address register, and the beat size and burst length come from the control fields. A single-type conditional load always reads exactly one beat. Each accepted data beat goes into a shared data FIFO with the channel number as its tag. When the last beat is stored, the block reports the new program counter. If source incrementing is enabled, it also reports the new source address. The surrounding channel logic writes both values back.

Top module: `chld_exec`

## Requirements
- R1: Only a byte whose bits [7:2] are 000001 is claimed. Any other byte causes no read, no retire pulse and no fault.
- R2: With bit 0 (conditional flag) clear, a load is always performed, whatever `req_burst` is, with `arlen` equal to `src_blen`.
- R3: With bit 0 set, the load runs when bit 1 equals `req_burst` (1 = burst, 0 = single). A single load uses `arlen` = 0 and ignores `src_blen`; a burst load uses `src_blen`.
- R4: With bit 0 set and bit 1 different from `req_burst`, no read is issued. `retire` pulses in the cycle after acceptance with `pc_next` = `chan_pc` + 1, and `src_wr` stays low.
- R5: `araddr` equals the sampled `src_addr` and `arsize` equals `src_bsize`. While `arvalid` waits for `arready`, `arvalid`, `araddr` and `arlen` hold steady.
- R6: Every beat accepted (`rvalid` and `rready` both high) writes the FIFO in that same cycle, with `fifo_data` = `rdata` and `fifo_tag` = `CHAN_ID`, in arrival order.
- R7: While `fifo_full` is high, `rready` is low and no FIFO write happens.
- R8: `retire` is a one-cycle pulse, given the cycle after the beat that carries `rlast` is accepted, with `pc_next` = `chan_pc` + 1.
- R9: On retire of a load, `src_wr` equals the sampled `src_inc`. `src_next` = address + (`arlen` + 1) × 2^`arsize`.
- R10: A claimed byte offered with `mgr_thread` high gives a one-cycle `fault` pulse in the next cycle. It gives no read and no retire.
- R11: While `busy` is high, `instr_valid` is ignored.
- R12: After reset, `busy`, `arvalid`, `rready`, `fifo_wr`, `retire`, `src_wr` and `fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Instruction byte offered this cycle |
| instr_byte | input | 8 | Instruction byte |
| mgr_thread | input | 1 | Issuing thread is the manager thread |
| req_burst | input | 1 | Latched peripheral request type, 1 = burst |
| chan_pc | input | PCW | Channel program counter |
| src_addr | input | AW | Source address register |
| src_inc | input | 1 | Source increment enable |
| src_blen | input | 4 | Programmed source burst length minus one |
| src_bsize | input | 3 | Source beat size, log2 bytes |
| busy | output | 1 | A load is in progress |
| retire | output | 1 | Instruction retired this cycle |
| pc_next | output | PCW | Program counter to write back |
| src_wr | output | 1 | Write back the source address |
| src_next | output | AW | New source address |
| fault | output | 1 | Illegal issue pulse |
| arvalid | output | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| araddr | output | AW | Read address |
| arlen | output | 4 | Read beats minus one |
| arsize | output | 3 | Read beat size |
| rvalid | input | 1 | Read data valid |
| rready | output | 1 | Read data ready |
| rdata | input | DW | Read data |
| rlast | input | 1 | Last read beat |
| fifo_full | input | 1 | Shared data FIFO cannot take a write |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DW | FIFO write data |
| fifo_tag | output | CHW | Channel tag for the written data |

## Verification
The bench drives a single-type conditional load with a large programmed length. A design that forgot to force one beat would request eight beats and leave surplus FIFO writes and a late retire. Both polarities of request-type mismatch are offered; a wrong comparison would issue a read, and the slave model flags that as an unexpected address. Read data is stalled by a toggling FIFO-full flag and the address handshake is delayed, so a design that dropped or duplicated a beat, or moved the address while waiting, shows a data mismatch or a stability failure. A second byte is pushed while a load is busy, and manager-thread and foreign opcodes are offered; a design that accepted either would produce an extra retire, a fault, or a read.

// File: rtl/chld_pkg.sv
// Package: shared encodings for the channel load executor.
// Assumes: the opcode field occupies bits [7:2] of the instruction byte.
package chld_pkg;

    // Upper six bits that identify the load family.
    localparam logic [5:0] LD_FAMILY = 6'b000001;

    // Sequencer phases of the read engine.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } chld_state_e;

    // Outcome chosen by the decoder for an offered byte.
    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_SKIP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_FAULT = 2'd3
    } chld_action_e;

endpackage

// File: rtl/chld_decode.sv
// Module: chld_decode
// Purely combinational. It classifies an instruction byte as foreign, skipped,
// loaded or faulted, and picks the effective burst length.
// Assumes: req_burst is the request type the channel latched earlier.
module chld_decode
    import chld_pkg::*;
#(
    parameter int LENW = 4
) (
    input  logic [7:0]      instr_byte,
    input  logic            mgr_thread,
    input  logic            req_burst,
    input  logic [LENW-1:0] src_blen,
    output chld_action_e    action,
    output logic [LENW-1:0] eff_len
);

    logic claimed;
    logic cond_bit;
    logic burst_bit;

    assign claimed   = (instr_byte[7:2] == LD_FAMILY);
    assign cond_bit  = instr_byte[0];
    assign burst_bit = instr_byte[1];

    // Choose the action from family match, thread type and condition.
    always_comb begin
        if (!claimed) begin
            action = ACT_NONE;
        end else if (mgr_thread) begin
            action = ACT_FAULT;
        end else if (cond_bit && (burst_bit != req_burst)) begin
            action = ACT_SKIP;
        end else begin
            action = ACT_LOAD;
        end
    end

    // A conditional single load reads one beat; otherwise take the programmed length.
    always_comb begin
        if (cond_bit && !burst_bit) begin
            eff_len = '0;
        end else begin
            eff_len = src_blen;
        end
    end

endmodule

// File: rtl/chld_addr_step.sv
// Module: chld_addr_step
// Combinational. It computes the source address after a burst:
// base + (len + 1) << size.
// Assumes: the result wraps modulo 2^AW.
module chld_addr_step #(
    parameter int AW   = 32,
    parameter int LENW = 4,
    parameter int SZW  = 3
) (
    input  logic [AW-1:0]   base,
    input  logic [LENW-1:0] len,
    input  logic [SZW-1:0]  size,
    output logic [AW-1:0]   next
);

    logic [AW-1:0] beats;
    logic [AW-1:0] bytes;

    // Count of beats in the burst, widened to the address width.
    assign beats = AW'(len) + AW'(1);
    // Bytes moved by the burst.
    assign bytes = beats << size;
    // Advanced address.
    assign next  = base + bytes;

endmodule

// File: rtl/chld_rd_engine.sv
// Module: chld_rd_engine
// Sequencer for one instruction. It latches the operands, drives the read
// address phase, passes data beats to the FIFO, and produces the retire or
// fault pulse.
// Assumes: start is raised only while busy is low; step_addr is already
// derived from this block's araddr, arlen and arsize.
module chld_rd_engine
    import chld_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int PCW  = 32,
    parameter int LENW = 4,
    parameter int SZW  = 3,
    parameter int CHW  = 3,
    parameter logic [CHW-1:0] CHAN_ID = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  chld_action_e    action,
    input  logic [LENW-1:0] eff_len,
    input  logic [AW-1:0]   src_addr,
    input  logic [SZW-1:0]  src_bsize,
    input  logic            src_inc,
    input  logic [PCW-1:0]  chan_pc,
    input  logic [AW-1:0]   step_addr,
    output logic            busy,
    output logic            retire,
    output logic [PCW-1:0]  pc_next,
    output logic            src_wr,
    output logic [AW-1:0]   src_next,
    output logic            fault,
    output logic            arvalid,
    input  logic            arready,
    output logic [AW-1:0]   araddr,
    output logic [LENW-1:0] arlen,
    output logic [SZW-1:0]  arsize,
    input  logic            rvalid,
    output logic            rready,
    input  logic [DW-1:0]   rdata,
    input  logic            rlast,
    input  logic            fifo_full,
    output logic            fifo_wr,
    output logic [DW-1:0]   fifo_data,
    output logic [CHW-1:0]  fifo_tag
);

    chld_state_e    state;
    logic [AW-1:0]   addr_q;
    logic [LENW-1:0] len_q;
    logic [SZW-1:0]  size_q;
    logic            inc_q;
    logic [PCW-1:0]  pc_inc_q;
    logic            retire_q;
    logic            fault_q;
    logic            src_wr_q;
    logic [PCW-1:0]  pc_next_q;
    logic [AW-1:0]   src_next_q;
    logic            beat_ok;

    // A beat is taken when the slave offers it and the FIFO has room.
    assign beat_ok = (state == ST_DATA) && rvalid && !fifo_full;

    // Phase register, operand latches and the one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            len_q      <= '0;
            size_q     <= '0;
            inc_q      <= 1'b0;
            pc_inc_q   <= '0;
            retire_q   <= 1'b0;
            fault_q    <= 1'b0;
            src_wr_q   <= 1'b0;
            pc_next_q  <= '0;
            src_next_q <= '0;
        end else begin
            retire_q <= 1'b0;
            fault_q  <= 1'b0;
            src_wr_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        unique case (action)
                            ACT_SKIP: begin
                                retire_q  <= 1'b1;
                                pc_next_q <= chan_pc + PCW'(1);
                            end
                            ACT_LOAD: begin
                                addr_q   <= src_addr;
                                len_q    <= eff_len;
                                size_q   <= src_bsize;
                                inc_q    <= src_inc;
                                pc_inc_q <= chan_pc + PCW'(1);
                                state    <= ST_ADDR;
                            end
                            ACT_FAULT: begin
                                fault_q <= 1'b1;
                            end
                            default: begin
                            end
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (arready) begin
                        state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (beat_ok && rlast) begin
                        state      <= ST_IDLE;
                        retire_q   <= 1'b1;
                        pc_next_q  <= pc_inc_q;
                        src_wr_q   <= inc_q;
                        src_next_q <= step_addr;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Drive the read address channel from the latched operands.
    always_comb begin
        arvalid = (state == ST_ADDR);
        araddr  = addr_q;
        arlen   = len_q;
        arsize  = size_q;
    end

    // Read data acceptance and the FIFO write port.
    always_comb begin
        rready    = (state == ST_DATA) && !fifo_full;
        fifo_wr   = beat_ok;
        fifo_data = rdata;
        fifo_tag  = CHAN_ID;
    end

    // Result outputs.
    always_comb begin
        busy     = (state != ST_IDLE);
        retire   = retire_q;
        fault    = fault_q;
        src_wr   = src_wr_q;
        pc_next  = pc_next_q;
        src_next = src_next_q;
    end

endmodule

// File: rtl/chld_exec.sv
// Module: chld_exec (top)
// Channel load executor. An offered byte is decoded and accepted only while
// idle. The read engine then runs the instruction, and the address stepper
// supplies the write-back source address.
// Assumes: all channel register inputs are stable in the cycle instr_valid is high.
module chld_exec
    import chld_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int PCW  = 32,
    parameter int CHW  = 3,
    parameter logic [CHW-1:0] CHAN_ID = 3'd5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           instr_valid,
    input  logic [7:0]     instr_byte,
    input  logic           mgr_thread,
    input  logic           req_burst,
    input  logic [PCW-1:0] chan_pc,
    input  logic [AW-1:0]  src_addr,
    input  logic           src_inc,
    input  logic [3:0]     src_blen,
    input  logic [2:0]     src_bsize,
    output logic           busy,
    output logic           retire,
    output logic [PCW-1:0] pc_next,
    output logic           src_wr,
    output logic [AW-1:0]  src_next,
    output logic           fault,
    output logic           arvalid,
    input  logic           arready,
    output logic [AW-1:0]  araddr,
    output logic [3:0]     arlen,
    output logic [2:0]     arsize,
    input  logic           rvalid,
    output logic           rready,
    input  logic [DW-1:0]  rdata,
    input  logic           rlast,
    input  logic           fifo_full,
    output logic           fifo_wr,
    output logic [DW-1:0]  fifo_data,
    output logic [CHW-1:0] fifo_tag
);

    localparam int LENW = 4;
    localparam int SZW  = 3;

    chld_action_e    action;
    logic [LENW-1:0] eff_len;
    logic [AW-1:0]   step_addr;
    logic            start;

    // Accept an offered byte only while no load is in flight.
    assign start = instr_valid && !busy;

    chld_decode #(
        .LENW (LENW)
    ) u_decode (
        .instr_byte (instr_byte),
        .mgr_thread (mgr_thread),
        .req_burst  (req_burst),
        .src_blen   (src_blen),
        .action     (action),
        .eff_len    (eff_len)
    );

    chld_addr_step #(
        .AW   (AW),
        .LENW (LENW),
        .SZW  (SZW)
    ) u_step (
        .base (araddr),
        .len  (arlen),
        .size (arsize),
        .next (step_addr)
    );

    chld_rd_engine #(
        .AW      (AW),
        .DW      (DW),
        .PCW     (PCW),
        .LENW    (LENW),
        .SZW     (SZW),
        .CHW     (CHW),
        .CHAN_ID (CHAN_ID)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .action    (action),
        .eff_len   (eff_len),
        .src_addr  (src_addr),
        .src_bsize (src_bsize),
        .src_inc   (src_inc),
        .chan_pc   (chan_pc),
        .step_addr (step_addr),
        .busy      (busy),
        .retire    (retire),
        .pc_next   (pc_next),
        .src_wr    (src_wr),
        .src_next  (src_next),
        .fault     (fault),
        .arvalid   (arvalid),
        .arready   (arready),
        .araddr    (araddr),
        .arlen     (arlen),
        .arsize    (arsize),
        .rvalid    (rvalid),
        .rready    (rready),
        .rdata     (rdata),
        .rlast     (rlast),
        .fifo_full (fifo_full),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data),
        .fifo_tag  (fifo_tag)
    );

endmodule

// File: rtl/chld_exec_chk.sv
// Module: chld_exec_chk
// Protocol and pulse checks on the executor's ports; attached by bind.
// Assumes: rst_n is synchronous and active low.
module chld_exec_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arvalid,
    input logic          arready,
    input logic [AW-1:0] araddr,
    input logic [3:0]    arlen,
    input logic          rready,
    input logic          fifo_full,
    input logic          fifo_wr,
    input logic          retire,
    input logic          fault,
    input logic          busy
);

    // R5: a waiting address request keeps its contents.
    p_ar_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arvalid && !arready) |=> (arvalid && $stable(araddr) && $stable(arlen)));

    // R7: no acceptance and no FIFO write while the FIFO is full.
    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> (!rready && !fifo_wr));

    // R8: retire lasts one cycle.
    p_retire_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // R10: fault lasts one cycle.
    p_fault_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R10: a fault comes with no read request and no retire.
    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!arvalid && !retire));

    // R11: the engine is free again when it retires.
    p_retire_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> !busy);

endmodule

bind chld_exec chld_exec_chk #(
    .AW (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arvalid   (arvalid),
    .arready   (arready),
    .araddr    (araddr),
    .arlen     (arlen),
    .rready    (rready),
    .fifo_full (fifo_full),
    .fifo_wr   (fifo_wr),
    .retire    (retire),
    .fault     (fault),
    .busy      (busy)
);

// File: tb/chld_exec_bench.sv
// Scoreboard bench. Driver tasks queue the expected reads, FIFO items and
// retirements. Monitors and a slave model compare them at the falling edge.
module chld_exec_bench;

    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int PCW = 32;
    localparam int CHW = 3;
    localparam logic [CHW-1:0] TAG = 3'd5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           instr_valid = 1'b0;
    logic [7:0]     instr_byte = '0;
    logic           mgr_thread = 1'b0;
    logic           req_burst = 1'b0;
    logic [PCW-1:0] chan_pc = '0;
    logic [AW-1:0]  src_addr = '0;
    logic           src_inc = 1'b0;
    logic [3:0]     src_blen = '0;
    logic [2:0]     src_bsize = '0;
    logic           busy, retire, src_wr, fault, arvalid, rready, fifo_wr;
    logic [PCW-1:0] pc_next;
    logic [AW-1:0]  src_next, araddr;
    logic [3:0]     arlen;
    logic [2:0]     arsize;
    logic [DW-1:0]  fifo_data;
    logic [CHW-1:0] fifo_tag;
    logic           arready = 1'b0;
    logic           rvalid = 1'b0;
    logic [DW-1:0]  rdata = '0;
    logic           rlast = 1'b0;
    logic           fifo_full = 1'b0;

    int checks = 0;
    int errors = 0;
    int ar_gap = 0;
    bit stall_mode = 1'b0;
    int retires_seen = 0;
    int retires_exp = 0;
    int faults_exp = 0;
    logic [DW-1:0] data_seq = 32'hA500_0000;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [3:0]    len;
        logic [2:0]    size;
    } ar_item_t;

    typedef struct packed {
        logic [PCW-1:0] pc;
        logic           wr;
        logic [AW-1:0]  addr;
    } ret_item_t;

    ar_item_t      ar_q[$];
    ret_item_t     ret_q[$];
    logic [DW-1:0] data_q[$];

    always #5 clk = ~clk;

    chld_exec #(
        .AW(AW), .DW(DW), .PCW(PCW), .CHW(CHW), .CHAN_ID(TAG)
    ) u_chld_exec (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_byte(instr_byte),
        .mgr_thread(mgr_thread), .req_burst(req_burst), .chan_pc(chan_pc),
        .src_addr(src_addr), .src_inc(src_inc), .src_blen(src_blen), .src_bsize(src_bsize),
        .busy(busy), .retire(retire), .pc_next(pc_next), .src_wr(src_wr),
        .src_next(src_next), .fault(fault), .arvalid(arvalid), .arready(arready),
        .araddr(araddr), .arlen(arlen), .arsize(arsize), .rvalid(rvalid),
        .rready(rready), .rdata(rdata), .rlast(rlast), .fifo_full(fifo_full),
        .fifo_wr(fifo_wr), .fifo_data(fifo_data), .fifo_tag(fifo_tag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Slave model: answers read requests and checks them against the queue (R2, R3, R5).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && arvalid) begin
                int nbeats;
                ar_item_t e;
                repeat (ar_gap) @(negedge clk);
                @(posedge clk); #1 arready = 1'b1;
                @(negedge clk);
                if (ar_q.size() == 0) begin
                    check(1'b0, "R4/R10", "unexpected read request", 64'(araddr), 0);
                    e = '0;
                end else begin
                    e = ar_q.pop_front();
                    check(araddr == e.addr, "R5", "araddr", 64'(araddr), 64'(e.addr));
                    check(arsize == e.size, "R5", "arsize", 64'(arsize), 64'(e.size));
                    check(arlen == e.len, "R2/R3", "arlen", 64'(arlen), 64'(e.len));
                end
                nbeats = int'(arlen) + 1;
                @(posedge clk); #1 arready = 1'b0;
                for (int b = 0; b < nbeats; b++) begin
                    rvalid = 1'b1;
                    rdata  = data_seq;
                    rlast  = (b == nbeats - 1);
                    data_q.push_back(data_seq);
                    data_seq = data_seq + 32'h11;
                    do @(negedge clk); while (!rready);
                    @(posedge clk); #1;
                end
                rvalid = 1'b0;
                rlast  = 1'b0;
            end
        end
    end

    // FIFO-full generator used for the stall cases (R7).
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            fifo_full = stall_mode && cyc[1];
        end
    end

    // Monitor: FIFO writes, retirements, faults and address stability.
    initial begin
        bit prev_wait = 1'b0;
        logic [AW-1:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_wait)
                    check(arvalid && araddr == prev_addr, "R5", "held request",
                          64'(araddr), 64'(prev_addr));
                prev_wait = arvalid && !arready;
                prev_addr = araddr;
                if (fifo_full && rvalid)
                    check(!rready && !fifo_wr, "R7", "accept while full",
                          64'({rready, fifo_wr}), 0);
                if (fifo_wr) begin
                    if (data_q.size() == 0) begin
                        check(1'b0, "R6", "extra FIFO write", 64'(fifo_data), 0);
                    end else begin
                        logic [DW-1:0] d;
                        d = data_q.pop_front();
                        check(fifo_data == d, "R6", "fifo_data", 64'(fifo_data), 64'(d));
                        check(fifo_tag == TAG, "R6", "fifo_tag", 64'(fifo_tag), 64'(TAG));
                    end
                end
                if (retire) begin
                    retires_seen++;
                    if (ret_q.size() == 0) begin
                        check(1'b0, "R1/R11", "unexpected retire", 64'(pc_next), 0);
                    end else begin
                        ret_item_t r;
                        r = ret_q.pop_front();
                        check(pc_next == r.pc, "R8", "pc_next", 64'(pc_next), 64'(r.pc));
                        check(src_wr == r.wr, "R9", "src_wr", 64'(src_wr), 64'(r.wr));
                        if (r.wr)
                            check(src_next == r.addr, "R9", "src_next",
                                  64'(src_next), 64'(r.addr));
                    end
                end
                if (fault) begin
                    check(faults_exp > 0, "R10", "fault pulse", 1, 64'(faults_exp));
                    if (faults_exp > 0) faults_exp--;
                end
            end
        end
    end

    // Driver: offer one byte and queue what it should produce.
    task automatic issue(input logic [7:0] op, input bit mgr, input bit rqb,
                         input logic [PCW-1:0] pc, input logic [AW-1:0] addr,
                         input bit inc, input logic [3:0] blen, input logic [2:0] bsz,
                         input bit intrude);
        bit claimed, cond, bsb;
        ar_item_t a;
        ret_item_t r;
        logic [3:0] len;
        claimed = (op[7:2] == 6'b000001);
        cond = op[0];
        bsb = op[1];
        len = (cond && !bsb) ? 4'd0 : blen;
        if (claimed && mgr) begin
            faults_exp++;
        end else if (claimed && cond && (bsb != rqb)) begin
            r.pc = pc + 1; r.wr = 1'b0; r.addr = '0;
            ret_q.push_back(r); retires_exp++;
        end else if (claimed) begin
            a.addr = addr; a.len = len; a.size = bsz;
            ar_q.push_back(a);
            r.pc = pc + 1; r.wr = inc;
            r.addr = addr + ((AW'(len) + 1) << bsz);
            ret_q.push_back(r); retires_exp++;
        end
        @(posedge clk); #1;
        instr_valid = 1'b1; instr_byte = op; mgr_thread = mgr; req_burst = rqb;
        chan_pc = pc; src_addr = addr; src_inc = inc; src_blen = blen; src_bsize = bsz;
        @(posedge clk); #1;
        instr_valid = 1'b0;
        if (intrude) begin
            @(negedge clk);
            check(busy, "R11", "busy during load", 64'(busy), 1);
            @(posedge clk); #1;
            instr_valid = 1'b1; instr_byte = 8'h05; req_burst = 1'b1; chan_pc = 32'h999;
            @(posedge clk); #1;
            instr_valid = 1'b0;
        end
        src_addr = 32'hDEAD_0000; src_blen = 4'hF; src_inc = ~inc;
        do @(negedge clk);
        while (busy || ret_q.size() != 0 || faults_exp != 0 || data_q.size() != 0);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WDOG", "timeout", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: idle outputs after reset.
        check(!busy && !arvalid && !rready && !fifo_wr, "R12", "idle controls",
              64'({busy, arvalid, rready, fifo_wr}), 0);
        check(!retire && !src_wr && !fault, "R12", "idle pulses",
              64'({retire, src_wr, fault}), 0);
        // R1: foreign byte is not claimed.
        issue(8'h08, 1'b0, 1'b0, 32'h10, 32'h100, 1'b1, 4'd2, 3'd2, 1'b0);
        issue(8'hFF, 1'b1, 1'b0, 32'h10, 32'h100, 1'b1, 4'd2, 3'd2, 1'b0);
        // R2, R6, R8, R9: unconditional burst with increment.
        issue(8'h04, 1'b0, 1'b1, 32'h20, 32'h1000, 1'b1, 4'd3, 3'd2, 1'b0);
        // R2, R9: unconditional with single request type, no increment.
        issue(8'h04, 1'b0, 1'b0, 32'h30, 32'h2000, 1'b0, 4'd1, 3'd1, 1'b0);
        // R3: conditional single match ignores the programmed length.
        issue(8'h05, 1'b0, 1'b0, 32'h40, 32'h3000, 1'b1, 4'd7, 3'd3, 1'b0);
        // R3: conditional burst match.
        issue(8'h07, 1'b0, 1'b1, 32'h50, 32'h4000, 1'b1, 4'd2, 3'd0, 1'b0);
        // R4: both mismatch polarities retire as no-operations.
        issue(8'h05, 1'b0, 1'b1, 32'h60, 32'h5000, 1'b1, 4'd2, 3'd2, 1'b0);
        issue(8'h07, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h5000, 1'b1, 4'd2, 3'd2, 1'b0);
        // R10: manager-thread issue faults.
        issue(8'h04, 1'b1, 1'b0, 32'h70, 32'h6000, 1'b1, 4'd2, 3'd2, 1'b0);
        // R5: delayed address acceptance.
        ar_gap = 3;
        issue(8'h06, 1'b0, 1'b1, 32'h80, 32'h7000, 1'b1, 4'd1, 3'd2, 1'b0);
        // R7: FIFO-full stalls across a long burst.
        ar_gap = 0;
        stall_mode = 1'b1;
        issue(8'h07, 1'b0, 1'b1, 32'h90, 32'hFFFF_FFF0, 1'b1, 4'd5, 3'd2, 1'b0);
        stall_mode = 1'b0;
        // R11: byte offered while busy is ignored.
        ar_gap = 4;
        issue(8'h04, 1'b0, 1'b0, 32'hA0, 32'h8000, 1'b1, 4'd0, 3'd2, 1'b1);
        ar_gap = 0;
        check(retires_seen == retires_exp, "R8/R11", "retire count",
              64'(retires_seen), 64'(retires_exp));
        check(ar_q.size() == 0, "R2/R3", "unanswered reads", 64'(ar_q.size()), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule